// File: doc/BRIEF.md
# Piecewise-Linear Transfer Curve Unit

This block maps every red, green and blue component of a pixel stream through a transfer curve, for example a linearising (degamma) or re-encoding (regamma) curve. Each component is looked up independently: its upper bits pick a curve point and its lower bits are the fraction inside that point's uniform segment. Every point stores a base value and a slope delta per channel. The result is the base plus the delta scaled by the fraction, rounded and saturated. Besides the two programmable curves there are two fixed curves computed in logic, a square law and a cube law, and a pass-through mode.

The curve storage is a pair of banks, A and B, used in ping-pong fashion. Software streams a new curve into the bank that is not in use, through one data port. It first clears the load position, then writes six words per point. A per-channel enable mask lets a reload touch only some channels. Software then switches the mode to the freshly loaded bank. The unit refuses any write aimed at the bank that is being read and flags the attempt. A status code tells which bank is feeding the output.

Top module: `pwl_xfer_unit`

## Requirements
- R1: With mode 0, or any mode value 5 to 7, each output component equals the input component one clock after a valid input; `out_valid_o` follows `pix_valid_i` with one clock of latency.
- R2: Mode 1 gives y = (x*x + 2^(W-1)) >> W for each component, where W is the component width (12 by default).
- R3: Mode 2 gives y = (x*x*x + 2^(2W-1)) >> 2W for each component.
- R4: Mode 3 reads bank A and mode 4 reads bank B. The point is the upper P bits of the component (P = 4 by default) and the fraction f is the lower W-P bits. The output is base + ((delta*f + 2^(W-P-1)) >> (W-P)), saturated to 2^W-1, using that channel's own entry.
- R5: Each point is loaded as six consecutive data writes, in this order: red base, green base, blue base, red delta, green delta, blue delta. The point index goes up by one after the sixth word and wraps from the last point to point 0.
- R6: `wr_mask_i` bit 0 enables red, bit 1 green and bit 2 blue. A word for a channel whose bit is 0 is not stored, but it still moves the load sequence on by one word.
- R7: `bank_sel_i` = 0 targets bank A and 1 targets bank B. `idx_clear_i` returns the load position to point 0, word 0. It takes precedence over a data write in the same cycle, and that write is dropped.
- R8: A data write that targets the bank currently selected by the mode (bank A in mode 3, bank B in mode 4) is not stored and does not advance the load sequence. From the next clock on it sets `err_o`, which stays high until reset.
- R9: One clock after a cycle with mode 3, `status_o` reads 9. After mode 4 it reads 10. After any other mode it reads 0.
- R10: After reset all outputs are 0 and both banks hold zeros. While `pix_valid_i` is low, `out_valid_o` drops and the output components keep their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 3 | Curve mode: 0 pass, 1 square, 2 cube, 3 bank A, 4 bank B |
| bank_sel_i | input | 1 | Load target: 0 bank A, 1 bank B |
| wr_mask_i | input | 3 | Per-channel write enable (bit0 red, bit1 green, bit2 blue) |
| idx_clear_i | input | 1 | Return load position to point 0, word 0 |
| data_we_i | input | 1 | Data word strobe |
| data_i | input | VAL_W | Data word (base or delta) |
| pix_valid_i | input | 1 | Input pixel valid |
| pix_r_i | input | VAL_W | Red component in |
| pix_g_i | input | VAL_W | Green component in |
| pix_b_i | input | VAL_W | Blue component in |
| out_valid_o | output | 1 | Output pixel valid |
| out_r_o | output | VAL_W | Red component out |
| out_g_o | output | VAL_W | Green component out |
| out_b_o | output | VAL_W | Blue component out |
| status_o | output | 4 | Bank in use: 9 A, 10 B, 0 none |
| err_o | output | 1 | Sticky flag for a write to the active bank |

## Verification
The bench loads both banks with different curves and sweeps every point on every channel. A swapped base/delta order or a skipped index shows up as wrong outputs from the sweep. A curve whose last segment overflows exercises saturation; a design without it would wrap to small values. A reload with green masked off checks that the sequence still moves on: a design that stalled on masked words would put later bases into the wrong slots. A clear issued mid-point, a clear coinciding with a write, a loader running past the last point, and blocked writes into the live bank all probe the load-position logic. A design that advanced on a blocked write, or that stored it, would corrupt the active curve or misalign the next load.

// File: rtl/pwl_xfer_pkg.sv
package pwl_xfer_pkg;
  typedef enum logic [2:0] {
    MODE_BYPASS = 3'd0,
    MODE_SQUARE = 3'd1,
    MODE_CUBE   = 3'd2,
    MODE_RAM_A  = 3'd3,
    MODE_RAM_B  = 3'd4
  } curve_mode_e;

  localparam int unsigned NUM_CH       = 3;
  localparam int unsigned NUM_BANKS    = 2;
  localparam int unsigned WORDS_PER_PT = 2 * NUM_CH;

  localparam logic [3:0] STAT_IDLE = 4'd0;
  localparam logic [3:0] STAT_A    = 4'd9;
  localparam logic [3:0] STAT_B    = 4'd10;
endpackage

// File: rtl/pwl_load_ctrl.sv
module pwl_load_ctrl
  import pwl_xfer_pkg::*;
#(
  parameter int unsigned IDX_W = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 idx_clear_i,
  input  logic                 data_we_i,
  input  logic                 bank_sel_i,
  input  logic [NUM_CH-1:0]    wr_mask_i,
  input  logic                 active_vld_i,
  input  logic                 active_bank_i,
  output logic [NUM_BANKS-1:0] bank_we_o,
  output logic [1:0]           ch_o,
  output logic                 is_delta_o,
  output logic [IDX_W-1:0]     pt_o,
  output logic                 err_o
);
  logic [2:0]       word_q;
  logic [IDX_W-1:0] pt_q;
  logic             err_q;
  logic             blocked, accept, last_word;

  always_comb begin
    blocked    = data_we_i && !idx_clear_i && active_vld_i && (bank_sel_i == active_bank_i);
    accept     = data_we_i && !idx_clear_i && !blocked;
    last_word  = (word_q == 3'(WORDS_PER_PT - 1));
    is_delta_o = (word_q >= 3'(NUM_CH));
    ch_o       = is_delta_o ? 2'(word_q - 3'(NUM_CH)) : word_q[1:0];
    bank_we_o  = '0;
    // masked words are dropped but still consume a slot
    if (accept && wr_mask_i[ch_o]) bank_we_o[bank_sel_i] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      pt_q   <= '0;
      err_q  <= 1'b0;
    end else begin
      if (idx_clear_i) begin
        word_q <= '0;
        pt_q   <= '0;
      end else if (accept) begin
        if (last_word) begin
          word_q <= '0;
          pt_q   <= pt_q + IDX_W'(1);
        end else begin
          word_q <= word_q + 3'd1;
        end
      end
      if (blocked) err_q <= 1'b1;
    end
  end

  assign pt_o  = pt_q;
  assign err_o = err_q;
endmodule

// File: rtl/pwl_curve_bank.sv
module pwl_curve_bank
  import pwl_xfer_pkg::*;
#(
  parameter int unsigned VAL_W = 12,
  parameter int unsigned IDX_W = 4
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          we_i,
  input  logic [1:0]                    wr_ch_i,
  input  logic                          wr_delta_i,
  input  logic [IDX_W-1:0]              wr_pt_i,
  input  logic [VAL_W-1:0]              wr_data_i,
  input  logic [NUM_CH-1:0][IDX_W-1:0]  rd_pt_i,
  output logic [NUM_CH-1:0][VAL_W-1:0]  rd_base_o,
  output logic [NUM_CH-1:0][VAL_W-1:0]  rd_delta_o
);
  localparam int unsigned NUM_PTS = 1 << IDX_W;

  logic [VAL_W-1:0] base_q  [NUM_PTS][NUM_CH];
  logic [VAL_W-1:0] delta_q [NUM_PTS][NUM_CH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int p = 0; p < NUM_PTS; p++) begin
        for (int c = 0; c < NUM_CH; c++) begin
          base_q[p][c]  <= '0;
          delta_q[p][c] <= '0;
        end
      end
    end else if (we_i) begin
      if (wr_delta_i) delta_q[wr_pt_i][wr_ch_i] <= wr_data_i;
      else            base_q[wr_pt_i][wr_ch_i]  <= wr_data_i;
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_rd
    assign rd_base_o[c]  = base_q[rd_pt_i[c]][c];
    assign rd_delta_o[c] = delta_q[rd_pt_i[c]][c];
  end
endmodule

// File: rtl/pwl_channel_eval.sv
module pwl_channel_eval
  import pwl_xfer_pkg::*;
#(
  parameter int unsigned VAL_W = 12,
  parameter int unsigned IDX_W = 4
) (
  input  logic [2:0]       mode_i,
  input  logic [VAL_W-1:0] x_i,
  input  logic [VAL_W-1:0] base_i,
  input  logic [VAL_W-1:0] delta_i,
  output logic [VAL_W-1:0] y_o
);
  localparam int unsigned FRAC_W = VAL_W - IDX_W;
  localparam int unsigned PW     = VAL_W + FRAC_W;
  localparam int unsigned SW     = 2 * VAL_W;
  localparam int unsigned CW     = 3 * VAL_W;

  logic [FRAC_W-1:0] frac;
  logic [PW-1:0]     prod;
  logic [VAL_W:0]    interp;
  logic [SW-1:0]     sq;
  logic [CW-1:0]     cube;
  logic [VAL_W-1:0]  lut_y, sq_y, cube_y;

  always_comb begin
    frac   = x_i[FRAC_W-1:0];
    prod   = PW'(delta_i) * PW'(frac) + (PW'(1) << (FRAC_W - 1));
    interp = {1'b0, base_i} + {1'b0, VAL_W'(prod >> FRAC_W)};
    lut_y  = interp[VAL_W] ? '1 : interp[VAL_W-1:0];

    sq     = SW'(x_i) * SW'(x_i) + (SW'(1) << (VAL_W - 1));
    sq_y   = VAL_W'(sq >> VAL_W);
    cube   = CW'(x_i) * CW'(x_i) * CW'(x_i) + (CW'(1) << (2 * VAL_W - 1));
    cube_y = VAL_W'(cube >> (2 * VAL_W));

    case (mode_i)
      MODE_SQUARE:            y_o = sq_y;
      MODE_CUBE:              y_o = cube_y;
      MODE_RAM_A, MODE_RAM_B: y_o = lut_y;
      default:                y_o = x_i;
    endcase
  end
endmodule

// File: rtl/pwl_xfer_unit.sv
module pwl_xfer_unit
  import pwl_xfer_pkg::*;
#(
  parameter int unsigned VAL_W = 12,
  parameter int unsigned IDX_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       mode_i,
  input  logic             bank_sel_i,
  input  logic [2:0]       wr_mask_i,
  input  logic             idx_clear_i,
  input  logic             data_we_i,
  input  logic [VAL_W-1:0] data_i,
  input  logic             pix_valid_i,
  input  logic [VAL_W-1:0] pix_r_i,
  input  logic [VAL_W-1:0] pix_g_i,
  input  logic [VAL_W-1:0] pix_b_i,
  output logic             out_valid_o,
  output logic [VAL_W-1:0] out_r_o,
  output logic [VAL_W-1:0] out_g_o,
  output logic [VAL_W-1:0] out_b_o,
  output logic [3:0]       status_o,
  output logic             err_o
);
  logic [NUM_CH-1:0][VAL_W-1:0]                 pix, y;
  logic [NUM_CH-1:0][IDX_W-1:0]                 rd_pt;
  logic [NUM_BANKS-1:0][NUM_CH-1:0][VAL_W-1:0] bank_base, bank_delta;
  logic [NUM_BANKS-1:0]                         bank_we;
  logic [1:0]                                   wr_ch;
  logic                                         wr_delta;
  logic [IDX_W-1:0]                             wr_pt;
  logic                                         active_vld, active_bank;
  logic [NUM_CH-1:0][VAL_W-1:0]                 out_q;
  logic                                         valid_q;
  logic [3:0]                                   status_q;

  assign pix         = {pix_b_i, pix_g_i, pix_r_i};
  assign active_vld  = (mode_i == MODE_RAM_A) || (mode_i == MODE_RAM_B);
  assign active_bank = (mode_i == MODE_RAM_B);

  pwl_load_ctrl #(.IDX_W(IDX_W)) u_load (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .idx_clear_i  (idx_clear_i),
    .data_we_i    (data_we_i),
    .bank_sel_i   (bank_sel_i),
    .wr_mask_i    (wr_mask_i),
    .active_vld_i (active_vld),
    .active_bank_i(active_bank),
    .bank_we_o    (bank_we),
    .ch_o         (wr_ch),
    .is_delta_o   (wr_delta),
    .pt_o         (wr_pt),
    .err_o        (err_o)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    pwl_curve_bank #(.VAL_W(VAL_W), .IDX_W(IDX_W)) u_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .we_i      (bank_we[b]),
      .wr_ch_i   (wr_ch),
      .wr_delta_i(wr_delta),
      .wr_pt_i   (wr_pt),
      .wr_data_i (data_i),
      .rd_pt_i   (rd_pt),
      .rd_base_o (bank_base[b]),
      .rd_delta_o(bank_delta[b])
    );
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign rd_pt[c] = pix[c][VAL_W-1 -: IDX_W];
    pwl_channel_eval #(.VAL_W(VAL_W), .IDX_W(IDX_W)) u_eval (
      .mode_i (mode_i),
      .x_i    (pix[c]),
      .base_i (bank_base[active_bank][c]),
      .delta_i(bank_delta[active_bank][c]),
      .y_o    (y[c])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q    <= '0;
      valid_q  <= 1'b0;
      status_q <= STAT_IDLE;
    end else begin
      valid_q <= pix_valid_i;
      if (pix_valid_i) out_q <= y;
      if (mode_i == MODE_RAM_A)      status_q <= STAT_A;
      else if (mode_i == MODE_RAM_B) status_q <= STAT_B;
      else                           status_q <= STAT_IDLE;
    end
  end

  assign out_valid_o = valid_q;
  assign out_r_o     = out_q[0];
  assign out_g_o     = out_q[1];
  assign out_b_o     = out_q[2];
  assign status_o    = status_q;
endmodule

// File: rtl/pwl_xfer_checker.sv
module pwl_xfer_checker #(
  parameter int unsigned VAL_W = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [2:0]       mode_i,
  input logic             bank_sel_i,
  input logic             data_we_i,
  input logic             idx_clear_i,
  input logic             pix_valid_i,
  input logic [VAL_W-1:0] pix_r_i,
  input logic             out_valid_o,
  input logic [VAL_W-1:0] out_r_o,
  input logic [3:0]       status_o,
  input logic             err_o
);
  p_bypass_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_i && mode_i == 3'd0 |=> out_r_o == $past(pix_r_i));

  p_valid_lat_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_i |=> out_valid_o);

  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pix_valid_i |=> !out_valid_o && $stable(out_r_o));

  p_blocked_err_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_we_i && !idx_clear_i &&
    ((mode_i == 3'd3 && !bank_sel_i) || (mode_i == 3'd4 && bank_sel_i)) |=> err_o);

  p_err_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);

  p_status_a_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == 3'd3 |=> status_o == 4'd9);

  p_status_b_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == 3'd4 |=> status_o == 4'd10);

  p_status_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i != 3'd3 && mode_i != 3'd4 |=> status_o == 4'd0);
endmodule

bind pwl_xfer_unit pwl_xfer_checker #(.VAL_W(VAL_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mode_i     (mode_i),
  .bank_sel_i (bank_sel_i),
  .data_we_i  (data_we_i),
  .idx_clear_i(idx_clear_i),
  .pix_valid_i(pix_valid_i),
  .pix_r_i    (pix_r_i),
  .out_valid_o(out_valid_o),
  .out_r_o    (out_r_o),
  .status_o   (status_o),
  .err_o      (err_o)
);

// File: tb/pwl_xfer_unit_bench.sv
`timescale 1ns/1ps
module pwl_xfer_unit_bench;
  localparam int W    = 12;
  localparam int PW   = 4;
  localparam int FW   = W - PW;
  localparam int NPTS = 1 << PW;
  localparam int MAXV = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [2:0]   mode = '0;
  logic         bank_sel = 1'b0;
  logic [2:0]   wr_mask = 3'd7;
  logic         idx_clear = 1'b0;
  logic         data_we = 1'b0;
  logic [W-1:0] data = '0;
  logic         pix_valid = 1'b0;
  logic [W-1:0] pr = '0, pg = '0, pb = '0;
  logic         out_valid;
  logic [W-1:0] out_r, out_g, out_b;
  logic [3:0]   status;
  logic         err;

  int n_checks = 0;
  int n_errors = 0;
  string cur_req = "R10";
  logic [31:0] seed = 32'h1234abcd;

  int m_base  [2][NPTS][3];
  int m_delta [2][NPTS][3];
  int m_word = 0, m_pt = 0, m_err = 0;
  int exp_out [3] = '{0, 0, 0};
  int exp_valid = 0, exp_status = 0;

  always #5 clk = ~clk;

  pwl_xfer_unit #(.VAL_W(W), .IDX_W(PW)) u_pwl_xfer_unit (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .bank_sel_i(bank_sel),
    .wr_mask_i(wr_mask), .idx_clear_i(idx_clear), .data_we_i(data_we), .data_i(data),
    .pix_valid_i(pix_valid), .pix_r_i(pr), .pix_g_i(pg), .pix_b_i(pb),
    .out_valid_o(out_valid), .out_r_o(out_r), .out_g_o(out_g), .out_b_o(out_b),
    .status_o(status), .err_o(err)
  );

  function automatic int ref_eval(int md, int x, int ch);
    longint t;
    int bk, p, f, y;
    case (md)
      1: begin t = (longint'(x) * x + (longint'(1) << (W - 1))) >> W; return int'(t); end
      2: begin t = (longint'(x) * x * x + (longint'(1) << (2 * W - 1))) >> (2 * W); return int'(t); end
      3, 4: begin
        bk = md - 3;
        p  = x >> FW;
        f  = x % (1 << FW);
        y  = m_base[bk][p][ch] + ((m_delta[bk][p][ch] * f + (1 << (FW - 1))) >> FW);
        return (y > MAXV) ? MAXV : y;
      end
      default: return x;
    endcase
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cyc();
    int act_bank, ch;
    int px [3];
    px = '{int'(pr), int'(pg), int'(pb)};
    if (pix_valid) for (int c = 0; c < 3; c++) exp_out[c] = ref_eval(int'(mode), px[c], c);
    exp_valid  = int'(pix_valid);
    exp_status = (mode == 3'd3) ? 9 : (mode == 3'd4) ? 10 : 0;
    act_bank   = (mode == 3'd3) ? 0 : (mode == 3'd4) ? 1 : -1;
    if (idx_clear) begin
      m_word = 0;
      m_pt   = 0;
    end else if (data_we) begin
      if (int'(bank_sel) == act_bank) m_err = 1;
      else begin
        ch = m_word % 3;
        if (wr_mask[ch]) begin
          if (m_word < 3) m_base[bank_sel][m_pt][ch] = int'(data);
          else            m_delta[bank_sel][m_pt][ch] = int'(data);
        end
        m_word++;
        if (m_word == 6) begin
          m_word = 0;
          m_pt   = (m_pt + 1) % NPTS;
        end
      end
    end
    @(posedge clk);
    @(negedge clk);
    chk(cur_req, "red", int'(out_r), exp_out[0]);
    chk(cur_req, "green", int'(out_g), exp_out[1]);
    chk(cur_req, "blue", int'(out_b), exp_out[2]);
    chk("R10", "valid", int'(out_valid), exp_valid);
    chk("R9", "status", int'(status), exp_status);
    chk("R8", "err", int'(err), m_err);
  endtask

  task automatic pix(input int md, input int r, input int g, input int b);
    mode = 3'(md); pix_valid = 1'b1;
    pr = W'(r); pg = W'(g); pb = W'(b);
    cyc();
    pix_valid = 1'b0;
  endtask

  task automatic rnd_pix(input int md, input int n);
    for (int i = 0; i < n; i++) begin
      seed = seed * 32'd1103515245 + 32'd12345;
      pix(md, int'(seed[27:16]), int'(seed[19:8]), int'(seed[31:20]));
    end
  endtask

  task automatic wr(input int d);
    data_we = 1'b1; data = W'(d);
    cyc();
    data_we = 1'b0;
  endtask

  task automatic clr();
    idx_clear = 1'b1;
    cyc();
    idx_clear = 1'b0;
  endtask

  function automatic int pt_word(int set, int p, int w);
    if (set == 0) return (w < 3) ? p * 250 + w * 10 : 250 + (w - 3) * 20 + ((p == 15) ? 300 : 0);
    return (w < 3) ? p * 200 + w * 7 + 5 : 180 + (w - 3) * 30;
  endfunction

  task automatic load(input int sel, input int mask, input int set, input int npts);
    bank_sel = sel[0]; wr_mask = 3'(mask);
    clr();
    for (int p = 0; p < npts; p++)
      for (int w = 0; w < 6; w++) wr(pt_word(set, p, w));
  endtask

  task automatic sweep(input int md);
    for (int p = 0; p < NPTS; p++) pix(md, p * 256 + 128, p * 256 + 64, p * 256 + 200);
  endtask

  initial begin
    for (int b = 0; b < 2; b++)
      for (int p = 0; p < NPTS; p++)
        for (int c = 0; c < 3; c++) begin
          m_base[b][p][c] = 0;
          m_delta[b][p][c] = 0;
        end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10: reset state
    chk("R10", "reset out", int'(out_r) + int'(out_g) + int'(out_b), 0);
    chk("R10", "reset flags", int'(out_valid) + int'(status) + int'(err), 0);
    cyc();

    cur_req = "R1";
    pix(0, 0, 0, 0); pix(0, 4095, 1, 2048); pix(0, 123, 456, 789);
    pix(6, 321, 654, 987); pix(7, 4095, 0, 17); pix(5, 10, 20, 30);

    cur_req = "R2";
    pix(1, 0, 4095, 2048); pix(1, 1, 64, 4094); rnd_pix(1, 8);

    cur_req = "R3";
    pix(2, 0, 4095, 2048); pix(2, 1, 300, 4000); rnd_pix(2, 8);

    cur_req = "R5";
    mode = 3'd0;
    load(0, 7, 0, NPTS);
    sweep(3);
    cur_req = "R4";
    pix(3, 0, 0, 0); pix(3, 4095, 4095, 4095); pix(3, 255, 256, 3839);
    rnd_pix(3, 16);

    // R6: reload bank B with green masked off while A is live
    cur_req = "R6";
    mode = 3'd3;
    load(1, 5, 1, NPTS);
    sweep(4);

    // R7: clear mid-point, clear colliding with a write
    cur_req = "R7";
    mode = 3'd3; bank_sel = 1'b1; wr_mask = 3'd7;
    clr();
    wr(4000); wr(4001); wr(4002); wr(4003);
    clr();
    idx_clear = 1'b1; data_we = 1'b1; data = W'(3333);
    cyc();
    idx_clear = 1'b0; data_we = 1'b0;
    for (int w = 0; w < 6; w++) wr(1000 + w * 50);
    pix(4, 128, 100, 200); pix(4, 384, 300, 500);

    // R8: writes into the live bank
    cur_req = "R8";
    mode = 3'd4; bank_sel = 1'b1;
    wr(999); wr(998); wr(997);
    mode = 3'd3; bank_sel = 1'b0;
    wr(996);
    mode = 3'd3; bank_sel = 1'b1;
    wr(1500); wr(1501);
    pix(4, 128, 100, 200); pix(4, 384, 300, 500); pix(4, 640, 700, 900);

    // R5: loader running past the last point wraps to point 0
    cur_req = "R5";
    mode = 3'd4;
    load(0, 7, 0, NPTS + 1);
    pix(3, 64, 128, 250); pix(3, 300, 600, 900);

    cur_req = "R10";
    pix_valid = 1'b0;
    for (int i = 0; i < 4; i++) begin
      mode = 3'(i); pr = W'(i * 1000 + 7); pg = W'(i * 50); pb = W'(4095 - i);
      cyc();
    end

    cur_req = "R9";
    for (int m = 0; m < 8; m++) pix(m, 700 + m, 1700 + m, 2700 + m);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule